// File: doc/BRIEF.md
# Synchronous Slave Serial Receiver

This block receives words from a synchronous serial link in which a remote master drives both the bit clock and the data line. Bits are taken on each falling edge of the incoming bit clock, least significant bit first, and collected in a shift register. A word is 8 bits, or 9 bits when the extended-word mode is on. When the last bit of a word arrives, the word is copied into a holding register. A completion flag is then raised, and an interrupt request follows if interrupts are enabled.

Software drives the block through a small register port. One control register holds port enable, synchronous mode, clock-source select (clear means the clock comes from outside), extended-word mode, continuous receive enable, a single-shot receive enable and interrupt enable. A status register shows the ninth bit, the overrun flag and the completion flag. A data register returns the low 8 bits of the word.

In a low-power state the link inputs skip the two-flop synchronizer and are captured directly. A finished word then raises a wake request. An overrun stops reception until continuous receive enable is cleared. Clearing that enable also throws away any partly received word.

Top module: `sync_slave_rx`

## Requirements
- R1: After reset, the control register and status register read 0, and `irq_o` and `wake_o` are low.
- R2: Words are assembled only when port enable (control bit 0) and synchronous mode (bit 1) are set, clock-source select (bit 2) is clear and continuous receive (bit 4) is set. With any of these conditions unmet, no word completes.
- R3: The single-shot receive enable (control bit 5) has no effect. With it set and continuous receive clear, no word completes.
- R4: Data is sampled on falling edges of `sclk_i`, least significant bit first. After 8 edges with extended mode (bit 3) clear, the word appears in the data register (address 2) and the completion flag (status bit 2) is set.
- R5: With extended mode set, a word is 9 bits long. The ninth bit appears in status bit 0, and the data register holds the low 8 bits.
- R6: `irq_o` is high exactly when the completion flag is set and interrupt enable (control bit 6) is set.
- R7: Reading the data register clears the completion flag, and with it `irq_o`, on the following clock.
- R8: If a word completes while the completion flag is still set, the overrun flag (status bit 1) is set and the new word is discarded. Further words are refused until continuous receive is cleared, and clearing it clears the overrun flag.
- R9: Clearing continuous receive abandons a partly received word. The next word after re-enabling is assembled from its own bits only.
- R10: While `sleep_i` is high, the inputs are captured without the synchronizer, and `wake_o` follows `irq_o`. While `sleep_i` is low, `wake_o` stays low.
- R11: A read returns its value on `rdata_o` one clock after `rd_en_i`. Address 0 reads back the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Bit clock from the remote master |
| sdata_i | input | 1 | Serial data from the remote master |
| sleep_i | input | 1 | Low-power state indication; selects direct capture |
| wr_en_i | input | 1 | Write strobe for the control register |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 2 | Register address: 0 control, 1 status, 2 data |
| wdata_i | input | 7 | Control write data |
| rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Receive-complete interrupt request |
| wake_o | output | 1 | Wake request during low-power state |

## Verification
A falling edge on `sclk_i` reaches the completion flag four clocks later through the synchronizer, or three clocks later in the low-power state. `irq_o` changes in the same cycle as the flag. A read result is valid one clock after the strobe, and a data read clears the flag on that same clock. Each bench task therefore holds the bit clock low and then high for four clocks after the last falling edge, which leaves eight clocks before any status is sampled. Results are always sampled on the falling system-clock edge after the registering rising edge.

// File: rtl/sspr_pkg.sv
package sspr_pkg;
  localparam int CTRL_W = 7;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  // bit 0 is port_en, bit 6 is irq_en
  typedef struct packed {
    logic irq_en;
    logic single_en;
    logic cont_en;
    logic rx9;
    logic clk_master;
    logic sync_mode;
    logic port_en;
  } ctrl_t;
endpackage

// File: rtl/sspr_sync.sv
module sspr_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bypass,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[0] <= INIT;
        else     stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= INIT;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign q = bypass ? stg[0] : stg[STAGES-1];
endmodule

// File: rtl/sspr_shift.sv
module sspr_shift #(
  parameter int DATA_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            enable,
  input  logic            rx9,
  input  logic            sclk_s,
  input  logic            sdat_s,
  output logic            word_vld,
  output logic [DATA_W:0] word
);
  localparam int WORD_W = DATA_W + 1;
  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST8 = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] LAST9 = CNT_W'(DATA_W);

  logic              sclk_d;
  logic              fall;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  last;
  logic [WORD_W-1:0] sh;
  logic [WORD_W-1:0] sh_nxt;

  assign fall = sclk_d & ~sclk_s;
  assign last = rx9 ? LAST9 : LAST8;

  always_comb begin
    sh_nxt = sh;
    sh_nxt[cnt] = sdat_s;
  end

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b0;
    else     sclk_d <= sclk_s;
  end

  always_ff @(posedge clk) begin
    word_vld <= 1'b0;
    if (rst) begin
      cnt  <= '0;
      sh   <= '0;
      word <= '0;
    end else if (!enable) begin
      cnt <= '0;
      sh  <= '0;
    end else if (fall) begin
      if (cnt == last) begin
        word     <= sh_nxt;
        word_vld <= 1'b1;
        cnt      <= '0;
        sh       <= '0;
      end else begin
        sh  <= sh_nxt;
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sspr_regs.sv
module sspr_regs
  import sspr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              word_vld,
  input  logic [DATA_W:0]   word,
  output ctrl_t             ctrl,
  output logic [DATA_W-1:0] rdata,
  output logic              done,
  output logic              ovf,
  output logic              irq
);
  logic [DATA_W-1:0] data_q;
  logic              bit9_q;
  logic              rd_data;

  assign rd_data = rd_en && (addr == ADDR_DATA);
  assign irq     = done & ctrl.irq_en;

  always_ff @(posedge clk) begin
    if (rst) ctrl <= '0;
    else if (wr_en && addr == ADDR_CTRL) ctrl <= ctrl_t'(wdata);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      bit9_q <= 1'b0;
      done   <= 1'b0;
      ovf    <= 1'b0;
    end else begin
      if (rd_data) done <= 1'b0;
      if (!ctrl.cont_en) begin
        ovf <= 1'b0;
      end else if (word_vld) begin
        if (done) begin
          ovf <= 1'b1;
        end else begin
          data_q <= word[DATA_W-1:0];
          bit9_q <= word[DATA_W];
          done   <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) begin
      case (addr)
        ADDR_CTRL: rdata <= DATA_W'(ctrl);
        ADDR_STAT: rdata <= DATA_W'({done, ovf, bit9_q});
        ADDR_DATA: rdata <= data_q;
        default:   rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/sync_slave_rx.sv
module sync_slave_rx
  import sspr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              sleep_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [1:0]        addr_i,
  input  logic [6:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              irq_o,
  output logic              wake_o
);
  ctrl_t          ctrl;
  logic [1:0]     pins_s;
  logic           slave_ok;
  logic           active;
  logic           word_vld;
  logic [DATA_W:0] word;
  logic [DATA_W-1:0] rdata;
  logic           done_q;
  logic           ovf_q;

  sspr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .INIT(2'b01)) u_sync (
    .clk(clk), .rst(rst), .bypass(sleep_i),
    .d({sdata_i, sclk_i}), .q(pins_s)
  );

  assign slave_ok = ctrl.port_en & ctrl.sync_mode & ~ctrl.clk_master & ctrl.cont_en;
  assign active   = slave_ok & ~ovf_q;

  sspr_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .enable(active), .rx9(ctrl.rx9),
    .sclk_s(pins_s[0]), .sdat_s(pins_s[1]),
    .word_vld(word_vld), .word(word)
  );

  sspr_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en_i), .rd_en(rd_en_i), .addr(addr_i),
    .wdata(wdata_i), .word_vld(word_vld), .word(word), .ctrl(ctrl),
    .rdata(rdata), .done(done_q), .ovf(ovf_q), .irq(irq_o)
  );

  assign rdata_o = rdata[7:0];
  assign wake_o  = sleep_i & irq_o;
endmodule

// File: rtl/sync_slave_rx_chk.sv
module sync_slave_rx_chk (
  input logic       clk,
  input logic       rst,
  input logic       irq_o,
  input logic       wake_o,
  input logic       sleep_i,
  input logic       word_vld,
  input logic       done_q,
  input logic       ovf_q,
  input logic       cont_en,
  input logic       single_en,
  input logic       slave_ok,
  input logic       rd_en_i,
  input logic [1:0] addr_i
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (!irq_o && !done_q && !ovf_q));
  // R2
  gated_no_word_chk: assert property (@(posedge clk) disable iff (rst) !slave_ok |=> !word_vld);
  // R3
  single_ignored_chk: assert property (@(posedge clk) disable iff (rst) (single_en && !cont_en) |=> !word_vld);
  // R6
  irq_needs_done_chk: assert property (@(posedge clk) disable iff (rst) irq_o |-> done_q);
  // R7
  read_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && addr_i == 2'd2 && !word_vld) |=> !done_q);
  // R8
  overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
    (word_vld && done_q && cont_en) |=> ovf_q);
  // R8
  overrun_hold_chk: assert property (@(posedge clk) disable iff (rst) (ovf_q && cont_en) |=> ovf_q);
  // R10
  wake_gate_chk: assert property (@(posedge clk) disable iff (rst) wake_o |-> (irq_o && sleep_i));
endmodule

bind sync_slave_rx sync_slave_rx_chk chk_i (
  .clk(clk), .rst(rst), .irq_o(irq_o), .wake_o(wake_o), .sleep_i(sleep_i),
  .word_vld(word_vld), .done_q(done_q), .ovf_q(ovf_q), .cont_en(ctrl.cont_en),
  .single_en(ctrl.single_en), .slave_ok(slave_ok), .rd_en_i(rd_en_i), .addr_i(addr_i)
);

// File: tb/sync_slave_rx_tb.sv
module sync_slave_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int WDOG       = 100000;
  localparam logic [6:0] PEN = 7'h01, SYN = 7'h02, MST = 7'h04, RX9 = 7'h08,
                         CONT = 7'h10, SGL = 7'h20, IEN = 7'h40;
  localparam logic [6:0] BASE = PEN | SYN | CONT;

  logic clk = 1'b0, rst = 1'b1, sclk = 1'b1, sdata = 1'b0, sleep = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = '0;
  logic [6:0] wdata = '0;
  logic [7:0] rdata;
  logic irq, wake;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_slave_rx dut_i (
    .clk(clk), .rst(rst), .sclk_i(sclk), .sdata_i(sdata), .sleep_i(sleep),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq), .wake_o(wake)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] v);
    @(negedge clk); wr_en = 1'b1; addr = 2'd0; wdata = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; v = rdata;
  endtask

  task automatic send(input logic [8:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      sdata = v[i];
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
    end
    repeat (HALF) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(2'd0, v); check("R1 ctrl", v, 0);
    rd(2'd1, v); check("R1 stat", v, 0);
    check("R1 irq", irq, 0);
    check("R1 wake", wake, 0);
  endtask

  task automatic t_readback;
    logic [7:0] v;
    wr(7'h55); rd(2'd0, v); check("R11 ctrl readback", v, 8'h55);
    wr(7'h00); rd(2'd0, v); check("R11 ctrl zero", v, 0);
  endtask

  task automatic t_basic;
    logic [7:0] v;
    wr(BASE | IEN);
    send(9'h0A5, 8);
    check("R6 irq on done", irq, 1);
    rd(2'd1, v); check("R4 stat done", v, 8'h04);
    rd(2'd2, v); check("R4 data lsb first", v, 8'hA5);
    check("R7 irq cleared", irq, 0);
    rd(2'd1, v); check("R7 done cleared", v, 8'h00);
  endtask

  task automatic t_nine;
    logic [7:0] v;
    wr(BASE | RX9);
    send(9'h13C, 9);
    rd(2'd1, v); check("R5 ninth bit", v, 8'h05);
    rd(2'd2, v); check("R5 low byte", v, 8'h3C);
    send(9'h0C3, 9);
    rd(2'd1, v); check("R5 ninth bit zero", v, 8'h04);
    rd(2'd2, v); check("R5 low byte 2", v, 8'hC3);
  endtask

  task automatic t_gate;
    logic [7:0] v;
    wr(BASE | MST); send(9'h011, 8);
    rd(2'd1, v); check("R2 master clock", v, 0);
    wr(PEN | CONT); send(9'h022, 8);
    rd(2'd1, v); check("R2 async mode", v, 0);
    wr(SYN | CONT); send(9'h033, 8);
    rd(2'd1, v); check("R2 port off", v, 0);
  endtask

  task automatic t_single;
    logic [7:0] v;
    wr(PEN | SYN | SGL); send(9'h077, 8);
    rd(2'd1, v); check("R3 single ignored", v, 0);
  endtask

  task automatic t_mask;
    logic [7:0] v;
    wr(BASE); send(9'h081, 8);
    check("R6 irq masked", irq, 0);
    rd(2'd1, v); check("R6 done set", v, 8'h04);
    wr(BASE | IEN);
    check("R6 irq on enable", irq, 1);
    rd(2'd2, v); check("R6 data", v, 8'h81);
  endtask

  task automatic t_ovf;
    logic [7:0] v;
    wr(BASE);
    send(9'h012, 8); send(9'h034, 8);
    rd(2'd1, v); check("R8 ovf set", v, 8'h06);
    rd(2'd2, v); check("R8 first kept", v, 8'h12);
    send(9'h056, 8);
    rd(2'd1, v); check("R8 locked", v, 8'h02);
    wr(PEN | SYN);
    rd(2'd1, v); check("R8 ovf cleared", v, 0);
    wr(BASE); send(9'h078, 8);
    rd(2'd2, v); check("R8 resumed", v, 8'h78);
  endtask

  task automatic t_partial;
    logic [7:0] v;
    wr(BASE);
    send(9'h007, 3);
    wr(PEN | SYN); wr(BASE);
    send(9'h05A, 8);
    rd(2'd1, v); check("R9 done", v, 8'h04);
    rd(2'd2, v); check("R9 clean word", v, 8'h5A);
  endtask

  task automatic t_sleep;
    logic [7:0] v;
    wr(BASE | IEN);
    sleep = 1'b1;
    check("R10 no wake idle", wake, 0);
    send(9'h0E7, 8);
    check("R10 wake", wake, 1);
    sleep = 1'b0;
    @(negedge clk);
    check("R10 wake off awake", wake, 0);
    rd(2'd2, v); check("R10 data", v, 8'hE7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset; t_readback; t_basic; t_nine; t_gate; t_single;
    t_mask; t_ovf; t_partial; t_sleep;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule